// File: doc/BRIEF.md
# Indexed Voice Register File

This block holds the per-voice parameter words of a 32-voice synthesizer, and a small set of global control bytes. A host reaches all of them through four byte-wide port addresses. Two of these are select registers: one picks the voice and one picks the function code. The other two form a 16-bit data port, with one address for the low byte and one for the high byte. A function code in the write range stores into the addressed voice word. The matching code with bit 7 set reads that word back.

An access is a one-cycle strobe with a size flag. In a word access, either data address carries all 16 bits. In a byte access, only the lane that belongs to the chosen address changes, and the other lane keeps its stored value. Reads are combinational from the current select state. Voice stores are locked out while the run bit of the global reset byte is low. Writing that byte with the run bit low also returns the global control state to its idle values.

Top module: `voice_regfile`

## Requirements
- R1: Port address 0 is the voice select and port address 1 is the function select. Both hold the written byte and read it back zero-extended. Only bits 4:0 of the voice select choose the voice, so voice select 0x21 addresses the same words as voice select 0x01.
- R2: With function code f in 0x00..0x0D, a word write to port 2 or port 3 stores all 16 bits in the word of the selected voice and slot f. A word read with code f|0x80 returns that word. Each voice and slot pair is a separate word.
- R3: A byte write to port 2 replaces bits 7:0 of the addressed word with wdata_i[7:0] and leaves bits 15:8 unchanged.
- R4: A byte write to port 3 replaces bits 15:8 of the addressed word with wdata_i[7:0] and leaves bits 7:0 unchanged.
- R5: A byte read of port 2 returns bits 7:0 of the selected value. A byte read of port 3 returns bits 15:8. In both cases the upper byte of rdata_o is zero.
- R6: While bit 0 of the reset byte is 0, writes with codes 0x00..0x0D change no voice word. Bit 0 is 0 after power-up.
- R7: Code 0x0E writes the active-voice count byte and code 0x8E reads it. The count is 0xCD after power-up.
- R8: Any read code that has no register returns all ones: 0xFFFF for a word read and 0x00FF for a byte read. Codes 0x00..0x0D and 0x8F read as all ones.
- R9: Codes 0x41 (DMA control), 0x45 (timer control) and 0x4C (reset byte) write a global byte. The same code reads that byte back.
- R10: A write to code 0x4C with bit 0 low has several effects. DMA control and timer control become 0x00, and the count becomes 0xCD. The reset byte keeps the written value except that bits 2:1 are cleared.
- R11: After power-up, every voice word, both select registers and all global bytes except the count read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | 2 | Port address: 0 voice select, 1 function select, 2 data low, 3 data high |
| word_i | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| wdata_i | input | 16 | Write data; a byte access uses bits 7:0 |
| rdata_o | output | 16 | Combinational read data for addr_i and word_i |

## Verification
The hardest situation to reach is a lane merge into a word that already has distinct bytes. Getting there needs the run bit set through the global reset code, then the voice and slot selected, then a full word written, and only then a byte write. The bench scripts that whole order before each merge. It then reads the word back both as a word and as two bytes. The lock-out case is reached the other way round: a word is stored, the run bit is dropped, and the bench confirms that the same slot still holds its old value.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam logic [1:0] PORT_VSEL = 2'd0;
  localparam logic [1:0] PORT_FSEL = 2'd1;
  localparam logic [1:0] PORT_DLO  = 2'd2;
  localparam logic [1:0] PORT_DHI  = 2'd3;

  localparam logic [7:0] FN_COUNT  = 8'h0E;
  localparam logic [7:0] FN_DMA    = 8'h41;
  localparam logic [7:0] FN_TIMER  = 8'h45;
  localparam logic [7:0] FN_RESET  = 8'h4C;
  localparam logic [7:0] RD_FLAG   = 8'h80;
  localparam logic [7:0] COUNT_RST = 8'hCD;

  typedef struct packed {
    logic voice_wr;
    logic voice_rd;
    logic count_wr;
    logic count_rd;
    logic dma;
    logic timer;
    logic rst;
  } fn_dec_t;
endpackage

// File: rtl/vrf_decode.sv
module vrf_decode
  import vrf_pkg::*;
#(
  parameter int NUM_FUNCS = 14
) (
  input  logic [7:0] func_i,
  output fn_dec_t    dec_o
);
  localparam logic [6:0] LAST_FN = 7'(NUM_FUNCS - 1);

  always_comb begin
    dec_o          = '0;
    dec_o.voice_wr = (func_i[7] == 1'b0) && (func_i[6:0] <= LAST_FN);
    dec_o.voice_rd = (func_i[7] == 1'b1) && (func_i[6:0] <= LAST_FN);
    dec_o.count_wr = (func_i == FN_COUNT);
    dec_o.count_rd = (func_i == (FN_COUNT | RD_FLAG));
    dec_o.dma      = (func_i == FN_DMA);
    dec_o.timer    = (func_i == FN_TIMER);
    dec_o.rst      = (func_i == FN_RESET);
  end
endmodule

// File: rtl/vrf_bank.sv
module vrf_bank #(
  parameter int NUM_VOICES = 32,
  parameter int SLOT_W     = 4,
  parameter int DATA_W     = 16,
  localparam int VOICE_W   = $clog2(NUM_VOICES),
  localparam int IDX_W     = VOICE_W + SLOT_W,
  localparam int DEPTH     = NUM_VOICES << SLOT_W,
  localparam int LANES     = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i][l*8 +: 8] <= '0;
      end else if (we_i && be_i[l]) begin
        mem_q[idx_i][l*8 +: 8] <= wdata_i[l*8 +: 8];
      end
    end
  end

  assign rdata_o = mem_q[idx_i];

  // disabled lanes must hold their previous content
  p_lane_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !be_i[LANES-1]) |=>
      (mem_q[$past(idx_i)][DATA_W-1 -: 8] == $past(rdata_o[DATA_W-1 -: 8])));
  p_lane_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !be_i[0]) |=> (mem_q[$past(idx_i)][7:0] == $past(rdata_o[7:0])));
  p_no_we_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (mem_q[$past(idx_i)] == $past(rdata_o)));
endmodule

// File: rtl/voice_regfile.sv
module voice_regfile
  import vrf_pkg::*;
#(
  parameter int NUM_VOICES = 32,
  parameter int NUM_FUNCS  = 14,
  parameter int DATA_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int VOICE_W = $clog2(NUM_VOICES);
  localparam int SLOT_W  = $clog2(NUM_FUNCS);
  localparam int IDX_W   = VOICE_W + SLOT_W;
  localparam int LANES   = DATA_W / 8;

  logic [7:0]        vsel_q, fsel_q, count_q, dma_q, timer_q, rst_q;
  fn_dec_t           dec;
  logic              data_wr, is_hi, bank_we;
  logic [LANES-1:0]  bank_be;
  logic [DATA_W-1:0] bank_wdata, bank_rdata, raw;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        wbyte;

  vrf_decode #(.NUM_FUNCS(NUM_FUNCS)) u_dec (.func_i(fsel_q), .dec_o(dec));

  assign data_wr    = wr_i && addr_i[1];
  assign is_hi      = (addr_i == PORT_DHI);
  assign wbyte      = wdata_i[7:0];
  assign idx        = {vsel_q[VOICE_W-1:0], fsel_q[SLOT_W-1:0]};
  assign bank_be    = word_i ? '1 : (is_hi ? LANES'(2'b10) : LANES'(2'b01));
  assign bank_wdata = word_i ? wdata_i : {LANES{wbyte}};
  assign bank_we    = data_wr && dec.voice_wr && rst_q[0];

  vrf_bank #(
    .NUM_VOICES(NUM_VOICES), .SLOT_W(SLOT_W), .DATA_W(DATA_W)
  ) u_bank (
    .clk_i, .rst_ni, .we_i(bank_we), .be_i(bank_be), .idx_i(idx),
    .wdata_i(bank_wdata), .rdata_o(bank_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsel_q  <= '0;
      fsel_q  <= '0;
      count_q <= COUNT_RST;
      dma_q   <= '0;
      timer_q <= '0;
      rst_q   <= '0;
    end else if (wr_i) begin
      if (addr_i == PORT_VSEL) vsel_q <= wbyte;
      if (addr_i == PORT_FSEL) fsel_q <= wbyte;
      if (data_wr) begin
        if (dec.count_wr) count_q <= wbyte;
        if (dec.dma)      dma_q   <= wbyte;
        if (dec.timer)    timer_q <= wbyte;
        if (dec.rst) begin
          if (wbyte[0]) rst_q <= wbyte;
          else begin
            rst_q   <= wbyte & 8'hF9;
            dma_q   <= '0;
            timer_q <= '0;
            count_q <= COUNT_RST;
          end
        end
      end
    end
  end

  always_comb begin
    raw = '1;
    if (dec.voice_rd)      raw = bank_rdata;
    else if (dec.count_rd) raw = DATA_W'(count_q);
    else if (dec.dma)      raw = DATA_W'(dma_q);
    else if (dec.timer)    raw = DATA_W'(timer_q);
    else if (dec.rst)      raw = DATA_W'(rst_q);
  end

  always_comb begin
    case (addr_i)
      PORT_VSEL: rdata_o = DATA_W'(vsel_q);
      PORT_FSEL: rdata_o = DATA_W'(fsel_q);
      default:   rdata_o = word_i ? raw
                         : (is_hi ? DATA_W'(raw[DATA_W-1 -: 8]) : DATA_W'(raw[7:0]));
    endcase
  end

  p_lockout_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && dec.voice_wr && !rst_q[0]) |-> !bank_we);
  p_soft_reset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && dec.rst && !wbyte[0]) |=>
      (count_q == COUNT_RST && dma_q == 8'h00 && timer_q == 8'h00 && rst_q[2:1] == 2'b00));
  p_unsupported_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1] && word_i && fsel_q[7] && fsel_q[6:0] > 7'h0E) |-> (rdata_o == '1));
  p_byte_zero_ext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1] && !word_i) |-> (rdata_o[DATA_W-1 -: 8] == 8'h00));
endmodule

// File: tb/voice_regfile_test.sv
module voice_regfile_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        word = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  voice_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr),
    .word_i(word), .wdata_i(wdata), .rdata_o(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic put(input logic [1:0] a, input logic [15:0] d, input logic w);
    @(negedge clk);
    addr = a; wdata = d; word = w; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic get(input logic [1:0] a, input logic w, output logic [15:0] v);
    @(negedge clk);
    addr = a; word = w; wr = 1'b0;
    #1 v = rdata;
  endtask

  task automatic sel(input logic [7:0] v, input logic [7:0] f);
    put(2'd0, {8'h0, v}, 1'b0);
    put(2'd1, {8'h0, f}, 1'b0);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_voice(input logic [7:0] v, input logic [7:0] f, input string req,
                          input logic [15:0] exp);
    logic [15:0] r;
    sel(v, f | 8'h80);
    get(2'd2, 1'b1, r);
    check(req, r, exp);
  endtask

  task automatic wr_voice(input logic [7:0] v, input logic [7:0] f, input logic [15:0] d);
    sel(v, f);
    put(2'd2, d, 1'b1);
  endtask

  task automatic run_on();
    sel(8'h00, 8'h4C);
    put(2'd2, 16'h0001, 1'b0);
  endtask

  task automatic t_power_up();
    logic [15:0] r;
    get(2'd0, 1'b1, r); check("R11 vsel", r, 16'h0000);
    get(2'd1, 1'b1, r); check("R11 fsel", r, 16'h0000);
    rd_voice(8'd5, 8'h03, "R11 voice word", 16'h0000);
    sel(8'h00, 8'h8E); get(2'd2, 1'b0, r); check("R7 count reset", r, 16'h00CD);
    sel(8'h00, 8'h41); get(2'd2, 1'b1, r); check("R11 dma", r, 16'h0000);
  endtask

  task automatic t_lock_initial();
    wr_voice(8'd2, 8'h04, 16'hBEEF);
    rd_voice(8'd2, 8'h04, "R6 locked at power-up", 16'h0000);
  endtask

  task automatic t_word_rw();
    run_on();
    wr_voice(8'd3, 8'h00, 16'h1234);
    wr_voice(8'd3, 8'h0D, 16'hA5C3);
    sel(8'd4, 8'h00); put(2'd3, 16'h7777, 1'b1);
    rd_voice(8'd3, 8'h00, "R2 slot0", 16'h1234);
    rd_voice(8'd3, 8'h0D, "R2 slot13", 16'hA5C3);
    rd_voice(8'd4, 8'h00, "R2 word via high port", 16'h7777);
    rd_voice(8'd31, 8'h0D, "R2 untouched word", 16'h0000);
  endtask

  task automatic t_select_alias();
    logic [15:0] r;
    sel(8'h21, 8'h83);
    get(2'd0, 1'b1, r); check("R1 vsel readback", r, 16'h0021);
    get(2'd1, 1'b0, r); check("R1 fsel readback", r, 16'h0083);
    wr_voice(8'h21, 8'h05, 16'h0F0F);
    rd_voice(8'h01, 8'h05, "R1 voice alias", 16'h0F0F);
  endtask

  task automatic t_byte_merge();
    logic [15:0] r;
    wr_voice(8'd7, 8'h02, 16'hAABB);
    put(2'd2, 16'hFF11, 1'b0);
    rd_voice(8'd7, 8'h02, "R3 low lane merge", 16'hAA11);
    sel(8'd7, 8'h02);
    put(2'd3, 16'hEE22, 1'b0);
    rd_voice(8'd7, 8'h02, "R4 high lane merge", 16'h2211);
    get(2'd2, 1'b0, r); check("R5 low byte read", r, 16'h0011);
    get(2'd3, 1'b0, r); check("R5 high byte read", r, 16'h0022);
  endtask

  task automatic t_unsupported();
    logic [15:0] r;
    sel(8'd3, 8'h00); get(2'd2, 1'b1, r); check("R8 write code read", r, 16'hFFFF);
    sel(8'd3, 8'h8F); get(2'd2, 1'b1, r); check("R8 0x8F word", r, 16'hFFFF);
    get(2'd3, 1'b0, r); check("R8 byte", r, 16'h00FF);
  endtask

  task automatic t_globals();
    logic [15:0] r;
    sel(8'h00, 8'h0E); put(2'd2, 16'h0012, 1'b0);
    sel(8'h00, 8'h8E); get(2'd2, 1'b1, r); check("R7 count write", r, 16'h0012);
    sel(8'h00, 8'h41); put(2'd2, 16'h0063, 1'b0); get(2'd2, 1'b1, r); check("R9 dma", r, 16'h0063);
    sel(8'h00, 8'h45); put(2'd2, 16'h002C, 1'b0); get(2'd2, 1'b1, r); check("R9 timer", r, 16'h002C);
    sel(8'h00, 8'h4C); put(2'd2, 16'h0007, 1'b0); get(2'd2, 1'b1, r); check("R9 reset byte", r, 16'h0007);
  endtask

  task automatic t_soft_reset();
    logic [15:0] r;
    sel(8'h00, 8'h4C); put(2'd2, 16'h00F6, 1'b0);
    get(2'd2, 1'b1, r); check("R10 reset byte bits", r, 16'h00F0);
    sel(8'h00, 8'h41); get(2'd2, 1'b1, r); check("R10 dma cleared", r, 16'h0000);
    sel(8'h00, 8'h45); get(2'd2, 1'b1, r); check("R10 timer cleared", r, 16'h0000);
    sel(8'h00, 8'h8E); get(2'd2, 1'b1, r); check("R10 count restored", r, 16'h00CD);
    wr_voice(8'd3, 8'h00, 16'h9999);
    rd_voice(8'd3, 8'h00, "R6 locked after drop", 16'h1234);
    sel(8'd3, 8'h00); put(2'd3, 16'h0055, 1'b0);
    rd_voice(8'd3, 8'h00, "R6 byte locked", 16'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_power_up();
    t_lock_initial();
    t_word_rw();
    t_select_alias();
    t_byte_merge();
    t_unsupported();
    t_globals();
    t_soft_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual hung expected done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule